// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This block keeps the control-register state of a small in-order processor and does the hardware part of taking and leaving exceptions. Software reaches five registers by a 3-bit index: a processor status word, two saved copies of that word (one for ordinary exceptions, one for breaks) and a 32-bit interrupt enable mask. There is also a pending view that shows the live interrupt lines. Thirty-two level-sensitive interrupt inputs are gated by the per-line mask and by a global enable bit in status, and the result is one interrupt request to the core.

The core model signals four events with single-cycle strobes: exception entry, break entry, exception return and break return. An entry strobe comes with the address of the faulting instruction. An entry saves status into the matching saved register and stores the return address (fault address plus 4). It then masks interrupts, drops to supervisor mode, sets the exception-in-progress flag and redirects fetch to a fixed handler address. A return restores status from the matching saved register and redirects fetch to the stored return address. While the exception-in-progress flag is set, a further ordinary exception keeps the state saved by the first one. In a build without an MMU, the user-mode bit and the flag are held at zero.

Top module: `exc_ctrl_unit`

## Requirements
- R1: Reads are combinational by index: 0 status, 1 exception-saved status, 2 break-saved status, 3 interrupt enable, 4 interrupt pending. Indices 5 to 7 read zero. Status uses bit 0 for global interrupt enable, bit 1 for user mode and bit 2 for exception in progress, and its upper bits read zero. All registers reset to zero.
- R2: A write takes effect at the clock edge that samples it and is not visible before that edge. Status writes keep only bits 2:0. A write to index 4 changes nothing.
- R3: Bit n of the pending register (index 4) is the live level of interrupt input n.
- R4: irq_req_o is 1 exactly when status bit 0 is 1 and, for some n, enable bit n and input n are both 1.
- R5: Exception entry drives redirect_o with EXC_VEC in the same cycle. At the next edge it copies status into exception-saved status and stores fault_pc_i + 4 as the exception return address.
- R6: After either kind of entry, status bits 0 and 1 are 0 and bit 2 is 1. Bit 2 stays set until a CSR write to status or a return changes it.
- R7: Exception return redirects to the stored exception return address in the same cycle and loads status from exception-saved status at the next edge.
- R8: Break entry redirects to BRK_VEC, saves status into break-saved status and fault_pc_i + 4 as the break return address, and leaves exception-saved status unchanged. Break return redirects to the break return address and loads status from break-saved status.
- R9: An exception entry while status bit 2 is 1 still redirects to EXC_VEC but leaves exception-saved status and the exception return address unchanged.
- R10: With HAS_MMU = 0, status bits 1 and 2 always read zero, including after an entry.
- R11: Strobes in the same cycle are resolved in the order break entry, exception entry, break return, exception return. An event's update of a register overrides a CSR write to that register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_idx_i | input | 3 | Control-register index for read and write |
| csr_we_i | input | 1 | Write strobe |
| csr_wdata_i | input | DATA_W | Write data |
| csr_rdata_o | output | DATA_W | Read data for csr_idx_i |
| irq_i | input | NUM_IRQ | Level-sensitive interrupt lines |
| irq_req_o | output | 1 | Interrupt request to the core |
| exc_enter_i | input | 1 | Exception entry strobe |
| brk_enter_i | input | 1 | Break entry strobe |
| exc_leave_i | input | 1 | Exception return strobe |
| brk_leave_i | input | 1 | Break return strobe |
| fault_pc_i | input | ADDR_W | Faulting instruction address with an entry strobe |
| redirect_o | output | 1 | Fetch redirect valid |
| redirect_pc_o | output | ADDR_W | Fetch redirect target |

## Verification
The hardest state to reach from the ports is a nested exception. The flag has to be set by a first entry and left alone by software, and only then does the second entry arrive. The result shows up only later, as the target of the exception return. The stimulus takes a first exception from a known status, waits idle cycles, takes a second one with a different fault address, and then returns. The return target and the saved status must still be those of the first exception. Random rounds of mask, line and status values check the gating. Directed cases cover simultaneous strobes and an entry that coincides with a status write.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;

  localparam int STAT_W     = 3;
  localparam int STAT_GIE   = 0;
  localparam int STAT_UMODE = 1;
  localparam int STAT_INEXC = 2;

  typedef enum logic [2:0] {
    IDX_STAT      = 3'd0,
    IDX_EXC_SAVED = 3'd1,
    IDX_BRK_SAVED = 3'd2,
    IDX_IRQ_EN    = 3'd3,
    IDX_IRQ_LVL   = 3'd4
  } csr_idx_e;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_BRK_ENTER,
    EV_EXC_ENTER,
    EV_BRK_LEAVE,
    EV_EXC_LEAVE
  } ev_e;

endpackage

// File: rtl/exc_ev_dec.sv
module exc_ev_dec
  import exc_ctrl_pkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter logic [31:0] EXC_VEC = 32'h0000_0020,
  parameter logic [31:0] BRK_VEC = 32'h0000_0100
) (
  input  logic              exc_enter_i,
  input  logic              brk_enter_i,
  input  logic              exc_leave_i,
  input  logic              brk_leave_i,
  input  logic [ADDR_W-1:0] exc_ret_addr_i,
  input  logic [ADDR_W-1:0] brk_ret_addr_i,
  output ev_e               ev_o,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_pc_o
);

  // fixed priority: break entry wins
  always_comb begin
    ev_o          = EV_NONE;
    redirect_pc_o = '0;
    if (brk_enter_i) begin
      ev_o          = EV_BRK_ENTER;
      redirect_pc_o = ADDR_W'(BRK_VEC);
    end else if (exc_enter_i) begin
      ev_o          = EV_EXC_ENTER;
      redirect_pc_o = ADDR_W'(EXC_VEC);
    end else if (brk_leave_i) begin
      ev_o          = EV_BRK_LEAVE;
      redirect_pc_o = brk_ret_addr_i;
    end else if (exc_leave_i) begin
      ev_o          = EV_EXC_LEAVE;
      redirect_pc_o = exc_ret_addr_i;
    end
    redirect_o = (ev_o != EV_NONE);
  end

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter bit HAS_MMU = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ev_e               ev_i,
  input  logic [ADDR_W-1:0] fault_pc_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_idx_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [STAT_W-1:0] exc_saved_o,
  output logic [STAT_W-1:0] brk_saved_o,
  output logic [ADDR_W-1:0] exc_ret_addr_o,
  output logic [ADDR_W-1:0] brk_ret_addr_o
);

  localparam logic [STAT_W-1:0] STAT_MASK  = HAS_MMU ? 3'b111 : 3'b001;
  localparam logic [STAT_W-1:0] ENTER_STAT = HAS_MMU ? 3'b100 : 3'b000;

  logic [STAT_W-1:0] stat_q, exc_saved_q, brk_saved_q;
  logic [ADDR_W-1:0] exc_ret_q, brk_ret_q;
  logic [ADDR_W-1:0] ret_addr;
  logic              frozen;

  assign ret_addr = fault_pc_i + ADDR_W'(4);
  assign frozen   = HAS_MMU && stat_q[STAT_INEXC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q      <= '0;
      exc_saved_q <= '0;
      brk_saved_q <= '0;
      exc_ret_q   <= '0;
      brk_ret_q   <= '0;
    end else begin
      if (wr_en_i) begin
        case (wr_idx_i)
          IDX_STAT:      stat_q      <= wr_data_i & STAT_MASK;
          IDX_EXC_SAVED: exc_saved_q <= wr_data_i & STAT_MASK;
          IDX_BRK_SAVED: brk_saved_q <= wr_data_i & STAT_MASK;
          default: ;
        endcase
      end
      // events override a same-cycle software write
      case (ev_i)
        EV_EXC_ENTER: begin
          if (!frozen) begin
            exc_saved_q <= stat_q;
            exc_ret_q   <= ret_addr;
          end
          stat_q <= ENTER_STAT;
        end
        EV_BRK_ENTER: begin
          brk_saved_q <= stat_q;
          brk_ret_q   <= ret_addr;
          stat_q      <= ENTER_STAT;
        end
        EV_EXC_LEAVE: stat_q <= exc_saved_q;
        EV_BRK_LEAVE: stat_q <= brk_saved_q;
        default: ;
      endcase
    end
  end

  assign stat_o         = stat_q;
  assign exc_saved_o    = exc_saved_q;
  assign brk_saved_o    = brk_saved_q;
  assign exc_ret_addr_o = exc_ret_q;
  assign brk_ret_addr_o = brk_ret_q;

endmodule

// File: rtl/exc_irq_unit.sv
module exc_irq_unit #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_we_i,
  input  logic [NUM_IRQ-1:0] en_wdata_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               gie_i,
  output logic [NUM_IRQ-1:0] irq_en_o,
  output logic               irq_req_o
);

  logic [NUM_IRQ-1:0] en_q;
  logic [NUM_IRQ-1:0] hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    assign hit[g] = en_q[g] & irq_i[g];
  end

  assign irq_req_o = gie_i & (|hit);
  assign irq_en_o  = en_q;

endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
  import exc_ctrl_pkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter int          DATA_W  = 32,
  parameter int          NUM_IRQ = 32,
  parameter bit          HAS_MMU = 1'b1,
  parameter logic [31:0] EXC_VEC = 32'h0000_0020,
  parameter logic [31:0] BRK_VEC = 32'h0000_0100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         csr_idx_i,
  input  logic               csr_we_i,
  input  logic [DATA_W-1:0]  csr_wdata_i,
  output logic [DATA_W-1:0]  csr_rdata_o,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic               irq_req_o,
  input  logic               exc_enter_i,
  input  logic               brk_enter_i,
  input  logic               exc_leave_i,
  input  logic               brk_leave_i,
  input  logic [ADDR_W-1:0]  fault_pc_i,
  output logic               redirect_o,
  output logic [ADDR_W-1:0]  redirect_pc_o
);

  ev_e               ev;
  logic [STAT_W-1:0] stat_q, exc_saved_q, brk_saved_q;
  logic [ADDR_W-1:0] exc_ret_q, brk_ret_q;
  logic [NUM_IRQ-1:0] irq_en_q;
  logic              en_we;

  exc_ev_dec #(
    .ADDR_W (ADDR_W),
    .EXC_VEC(EXC_VEC),
    .BRK_VEC(BRK_VEC)
  ) u_dec (
    .exc_enter_i   (exc_enter_i),
    .brk_enter_i   (brk_enter_i),
    .exc_leave_i   (exc_leave_i),
    .brk_leave_i   (brk_leave_i),
    .exc_ret_addr_i(exc_ret_q),
    .brk_ret_addr_i(brk_ret_q),
    .ev_o          (ev),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o)
  );

  exc_state_regs #(
    .ADDR_W (ADDR_W),
    .HAS_MMU(HAS_MMU)
  ) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ev_i          (ev),
    .fault_pc_i    (fault_pc_i),
    .wr_en_i       (csr_we_i),
    .wr_idx_i      (csr_idx_i),
    .wr_data_i     (csr_wdata_i[STAT_W-1:0]),
    .stat_o        (stat_q),
    .exc_saved_o   (exc_saved_q),
    .brk_saved_o   (brk_saved_q),
    .exc_ret_addr_o(exc_ret_q),
    .brk_ret_addr_o(brk_ret_q)
  );

  assign en_we = csr_we_i && (csr_idx_i == IDX_IRQ_EN);

  exc_irq_unit #(
    .NUM_IRQ(NUM_IRQ)
  ) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_we_i   (en_we),
    .en_wdata_i(csr_wdata_i[NUM_IRQ-1:0]),
    .irq_i     (irq_i),
    .gie_i     (stat_q[STAT_GIE]),
    .irq_en_o  (irq_en_q),
    .irq_req_o (irq_req_o)
  );

  always_comb begin
    case (csr_idx_i)
      IDX_STAT:      csr_rdata_o = DATA_W'(stat_q);
      IDX_EXC_SAVED: csr_rdata_o = DATA_W'(exc_saved_q);
      IDX_BRK_SAVED: csr_rdata_o = DATA_W'(brk_saved_q);
      IDX_IRQ_EN:    csr_rdata_o = DATA_W'(irq_en_q);
      IDX_IRQ_LVL:   csr_rdata_o = DATA_W'(irq_i);
      default:       csr_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/exc_ctrl_unit_chk.sv
module exc_ctrl_unit_chk #(
  parameter int          ADDR_W  = 32,
  parameter int          DATA_W  = 32,
  parameter int          NUM_IRQ = 32,
  parameter bit          HAS_MMU = 1'b1,
  parameter logic [31:0] EXC_VEC = 32'h0000_0020
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [2:0]         csr_idx_i,
  input logic               csr_we_i,
  input logic [DATA_W-1:0]  csr_rdata_o,
  input logic [NUM_IRQ-1:0] irq_i,
  input logic               irq_req_o,
  input logic               exc_enter_i,
  input logic               brk_enter_i,
  input logic               exc_leave_i,
  input logic               brk_leave_i,
  input logic [ADDR_W-1:0]  redirect_pc_o,
  input logic [2:0]         stat_q,
  input logic [2:0]         exc_saved_q
);

  // R5
  exc_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_enter_i && !brk_enter_i) |-> redirect_pc_o == ADDR_W'(EXC_VEC));

  // R5
  exc_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_enter_i && !brk_enter_i && !(HAS_MMU && stat_q[2]))
      |=> exc_saved_q == $past(stat_q));

  // R9
  nest_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_enter_i && !brk_enter_i && stat_q[2] && !(csr_we_i && csr_idx_i == 3'd1))
      |=> $stable(exc_saved_q));

  // R6
  enter_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_enter_i || brk_enter_i) |=> (stat_q[0] == 1'b0 && stat_q[1] == 1'b0));

  // R7
  exc_leave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_leave_i && !exc_enter_i && !brk_enter_i && !brk_leave_i)
      |=> stat_q == $past(exc_saved_q));

  // R3
  lvl_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_idx_i == 3'd4) |-> csr_rdata_o == DATA_W'(irq_i));

  // R1
  undef_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_idx_i > 3'd4) |-> csr_rdata_o == '0);

  // R4
  gie_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_q[0] |-> !irq_req_o);

  // R10
  no_mmu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HAS_MMU |-> stat_q[2:1] == 2'b00);

endmodule

bind exc_ctrl_unit exc_ctrl_unit_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .NUM_IRQ(NUM_IRQ),
  .HAS_MMU(HAS_MMU),
  .EXC_VEC(EXC_VEC)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .csr_idx_i    (csr_idx_i),
  .csr_we_i     (csr_we_i),
  .csr_rdata_o  (csr_rdata_o),
  .irq_i        (irq_i),
  .irq_req_o    (irq_req_o),
  .exc_enter_i  (exc_enter_i),
  .brk_enter_i  (brk_enter_i),
  .exc_leave_i  (exc_leave_i),
  .brk_leave_i  (brk_leave_i),
  .redirect_pc_o(redirect_pc_o),
  .stat_q       (stat_q),
  .exc_saved_q  (exc_saved_q)
);

// File: tb/exc_ctrl_unit_tb.sv
`timescale 1ns/1ps
module exc_ctrl_unit_tb;

  localparam logic [31:0] EXC_VEC = 32'h0000_0020;
  localparam logic [31:0] BRK_VEC = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  csr_idx = '0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] rdata, rdata_nm;
  logic [31:0] irq = '0;
  logic        irq_req, irq_req_nm;
  logic        exc_enter = 0, brk_enter = 0, exc_leave = 0, brk_leave = 0;
  logic [31:0] fault_pc = '0;
  logic        redir, redir_nm;
  logic [31:0] redir_pc, redir_pc_nm;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  exc_ctrl_unit #(.HAS_MMU(1'b1), .EXC_VEC(EXC_VEC), .BRK_VEC(BRK_VEC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .csr_idx_i(csr_idx), .csr_we_i(csr_we),
    .csr_wdata_i(csr_wdata), .csr_rdata_o(rdata), .irq_i(irq), .irq_req_o(irq_req),
    .exc_enter_i(exc_enter), .brk_enter_i(brk_enter), .exc_leave_i(exc_leave),
    .brk_leave_i(brk_leave), .fault_pc_i(fault_pc), .redirect_o(redir),
    .redirect_pc_o(redir_pc));

  exc_ctrl_unit #(.HAS_MMU(1'b0), .EXC_VEC(EXC_VEC), .BRK_VEC(BRK_VEC)) u_dut_nommu (
    .clk_i(clk), .rst_ni(rst_n), .csr_idx_i(csr_idx), .csr_we_i(csr_we),
    .csr_wdata_i(csr_wdata), .csr_rdata_o(rdata_nm), .irq_i(irq), .irq_req_o(irq_req_nm),
    .exc_enter_i(exc_enter), .brk_enter_i(brk_enter), .exc_leave_i(exc_leave),
    .brk_leave_i(brk_leave), .fault_pc_i(fault_pc), .redirect_o(redir_nm),
    .redirect_pc_o(redir_pc_nm));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [2:0] idx, input logic [31:0] exp);
    csr_idx = idx;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic rd_chk_nm(input string req, input logic [2:0] idx, input logic [31:0] exp);
    csr_idx = idx;
    #1;
    chk(req, rdata_nm, exp);
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] data);
    @(negedge clk);
    csr_we = 1'b1; csr_idx = idx; csr_wdata = data;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  // kind: {brk_enter, exc_enter, brk_leave, exc_leave}
  task automatic strobe(input logic [3:0] kind, input logic [31:0] pc,
                        input logic [31:0] exp_pc, input string req);
    @(negedge clk);
    {brk_enter, exc_enter, brk_leave, exc_leave} = kind;
    fault_pc = pc;
    #1;
    chk(req, {31'd0, redir}, 32'd1);
    chk(req, redir_pc, exp_pc);
    @(negedge clk);
    {brk_enter, exc_enter, brk_leave, exc_leave} = 4'b0000;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] ien, lvl, st;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    rd_chk("R1 status reset", 3'd0, 32'd0);
    rd_chk("R1 enable reset", 3'd3, 32'd0);
    chk("R4 no request at reset", {31'd0, irq_req}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 undefined indices
    for (int i = 5; i < 8; i++) rd_chk("R1 undefined index", 3'(i), 32'd0);

    // R2 write visible only after edge
    @(negedge clk);
    csr_we = 1'b1; csr_idx = 3'd3; csr_wdata = 32'hA5A5_0001;
    #1;
    chk("R2 before edge", rdata, 32'd0);
    @(negedge clk);
    csr_we = 1'b0;
    rd_chk("R2 after edge", 3'd3, 32'hA5A5_0001);

    // R2/R3 pending write ignored
    irq = 32'h0000_1234;
    wr(3'd4, 32'hFFFF_FFFF);
    rd_chk("R2 pending write ignored", 3'd4, 32'h0000_1234);
    rd_chk("R2 enable untouched", 3'd3, 32'hA5A5_0001);

    // R2/R10 status write masking
    wr(3'd0, 32'hFFFF_FFFF);
    rd_chk("R2 status upper bits", 3'd0, 32'd7);
    rd_chk_nm("R10 no-mmu status write", 3'd0, 32'd1);

    // R3/R4 random rounds
    for (int i = 0; i < 40; i++) begin
      ien = (i % 3 == 0) ? (32'd1 << (i % 32)) : $urandom;
      lvl = (i % 4 == 0) ? 32'd0 : $urandom;
      st  = $urandom % 8;
      wr(3'd3, ien);
      wr(3'd0, st);
      irq = lvl;
      #1;
      chk("R4 request gating", {31'd0, irq_req}, {31'd0, st[0] && |(ien & lvl)});
      rd_chk("R3 pending live", 3'd4, lvl);
      rd_chk("R1 status read", 3'd0, st);
    end
    irq = '0;

    // R5/R6 exception entry
    wr(3'd0, 32'd3);
    strobe(4'b0100, 32'h0000_1000, EXC_VEC, "R5 entry redirect");
    rd_chk("R5 saved status", 3'd1, 32'd3);
    rd_chk("R6 status after entry", 3'd0, 32'd4);
    rd_chk_nm("R10 no-mmu after entry", 3'd0, 32'd0);
    repeat (3) @(negedge clk);
    rd_chk("R6 flag persists", 3'd0, 32'd4);

    // R9 nested exception
    strobe(4'b0100, 32'h0000_2000, EXC_VEC, "R9 nested redirect");
    rd_chk("R9 saved status frozen", 3'd1, 32'd3);
    strobe(4'b0001, 32'h0, 32'h0000_1004, "R9 R7 return address kept");
    rd_chk("R7 status restored", 3'd0, 32'd3);

    // R8 break
    wr(3'd0, 32'd1);
    strobe(4'b1000, 32'h0000_3000, BRK_VEC, "R8 break redirect");
    rd_chk("R8 break saved", 3'd2, 32'd1);
    rd_chk("R8 exception saved untouched", 3'd1, 32'd3);
    rd_chk("R6 status after break", 3'd0, 32'd4);
    strobe(4'b0010, 32'h0, 32'h0000_3004, "R8 break return");
    rd_chk("R8 status restored", 3'd0, 32'd1);

    // R11 simultaneous entries
    wr(3'd0, 32'd0);
    strobe(4'b1100, 32'h0000_4000, BRK_VEC, "R11 break wins");
    rd_chk("R11 break saved", 3'd2, 32'd0);
    rd_chk("R11 exception saved untouched", 3'd1, 32'd3);
    wr(3'd0, 32'd0);
    rd_chk("R6 software clears flag", 3'd0, 32'd0);

    // R11 entry overrides status write
    @(negedge clk);
    exc_enter = 1'b1; fault_pc = 32'h0000_5000;
    csr_we = 1'b1; csr_idx = 3'd0; csr_wdata = 32'd3;
    @(negedge clk);
    exc_enter = 1'b0; csr_we = 1'b0;
    rd_chk("R11 event beats write", 3'd0, 32'd4);
    rd_chk("R5 saved pre-entry status", 3'd1, 32'd0);
    strobe(4'b0001, 32'h0, 32'h0000_5004, "R7 return redirect");
    rd_chk("R7 status from saved", 3'd0, 32'd0);

    finish_run();
  end

endmodule